// File: doc/BRIEF.md
# PWM Output Override Stage

This block sits between the raw pulse-width waveforms of up to eight channels and their pins. It decides on each cycle whether a pin carries its normal waveform, a level forced by a force request, or a safe level required by a fault. Seven fault sources can each be enabled separately: four internal lines, two external lines whose active level can be chosen, and a debug line. Any enabled source that is active overrides every channel at once. Each channel keeps a fault hold register that stays set after the sources go quiet. The channel is released only when its own recovery trigger arrives.

The force path is independent of the fault path. Each channel takes its force request either from a shared force pin, whose active level can be chosen, or from a software force bit. A working copy of a 2-bit-per-channel force command decides the forced level. The working copy is refreshed from a shadow copy at a selectable moment: every cycle, on a counter reload pulse, on a sync pulse, or never.

Pin output is combinational from the raw waveforms and the override state, so a fault takes effect in the same cycle it appears. All state registers reset to "no override".

Top module: `pwm_override`

## Requirements
- R1: A fault is present in the same cycle when any of these holds: an enabled internal line (`intFault & intFaultEn`) is high; the debug line is high with `dbgFaultEn` set; or an enabled external line is at its active level, which is high when its `extActLow` bit is 0 and low when it is 1. A present fault overrides every channel. Sources whose enable bit is clear have no effect.
- R2: While a channel is fault-overridden, its 2-bit fault mode field at bits [2i+1:2i] selects the pin state: 0 drives 0 with output enabled, 1 drives 1 with output enabled, and 2 or 3 disables the output with `pwmOut` at 0.
- R3: A channel's fault hold is set on every clock edge where a fault is present. It cannot be cleared while a fault is present, whatever release events arrive.
- R4: A channel with recovery field (bits [2i+1:2i] of `recTrig`) equal to 0 is released on the first clock edge at which no fault is present.
- R5: Recovery field 1 releases the channel on the first edge with no fault present and `cntReload` high.
- R6: Recovery field 2 releases the channel on the first edge with no fault present where `recEvt` shows the selected transition since the previous edge. The transition is 0 to 1 when `recEdgeRise` is 1 and 1 to 0 when it is 0.
- R7: Recovery field 3 releases the channel on the first edge with no fault present and `faultClr` high.
- R8: Channel i requests force when `forceSrcSw[i]` is 1 and `swForce` is high, or when `forceSrcSw[i]` is 0 and `forceIn` XOR `forcePolLow` is 1. A requesting channel follows its working command field at bits [2i+1:2i]: 0 drives 0, 1 drives 1, 2 disables the output with `pwmOut` at 0, and 3 leaves the normal waveform.
- R9: The working force command is loaded from `forceCmdShadow` according to `forceTiming`: 0 loads on every edge, 1 on edges with `cntReload` high, 2 on edges with `syncIn` high, and 3 never.
- R10: A fault override takes precedence over a force override, and a force override takes precedence over the normal waveform.
- R11: With no override, `pwmOut[i]` equals `pwmRaw[i] ^ outInvert[i]` and `pwmOe[i]` is 1. Inversion does not apply to fault or forced levels.
- R12: When `outEnable[i]` is 0, `pwmOe[i]` and `pwmOut[i]` are 0 whatever else is active.
- R13: Reset clears every fault hold and sets every working force field to 3, so after reset the outputs follow R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwmRaw | input | NCH | Raw channel waveforms |
| outInvert | input | NCH | Per-channel inversion of the normal waveform |
| outEnable | input | NCH | Per-channel pin output enable |
| intFault | input | NINT | Internal fault lines, active high |
| intFaultEn | input | NINT | Enables for the internal lines |
| extFault | input | NEXT | External fault lines |
| extFaultEn | input | NEXT | Enables for the external lines |
| extActLow | input | NEXT | 1 makes the matching external line active low |
| dbgFault | input | 1 | Debug fault line, active high |
| dbgFaultEn | input | 1 | Enable for the debug line |
| faultMode | input | 2*NCH | Per-channel fault pin state |
| recTrig | input | 2*NCH | Per-channel recovery trigger select |
| recEvt | input | 1 | Hardware recovery event line |
| recEdgeRise | input | 1 | 1 selects the rising transition of recEvt, 0 the falling one |
| cntReload | input | 1 | Counter reload pulse |
| faultClr | input | 1 | Software fault-clear pulse |
| forceIn | input | 1 | Shared force request pin |
| forcePolLow | input | 1 | 1 makes forceIn active low |
| swForce | input | 1 | Software force request |
| forceSrcSw | input | NCH | Per-channel force source, 1 selects swForce |
| forceCmdShadow | input | 2*NCH | Shadow force command |
| forceTiming | input | 2 | Load moment of the working force command |
| syncIn | input | 1 | Sync pulse for command loading |
| pwmOut | output | NCH | Pin output level |
| pwmOe | output | NCH | Pin output enable |

## Verification
Each fault source is tried alone, including a disabled source and an external line in its active-low setting, to show that the combining logic honours the enables and polarity. The mixed per-channel recovery setup uses a raw pattern that differs from the fault levels on each channel pair. After each release event, exactly one pair of channels should return to its waveform, which separates the four triggers from one another. Release events that arrive while a fault is still present, and the unselected `recEvt` transition, show that these cannot release a channel. A table of raw, inversion and force-request patterns under a mixed force command separates the inversion, software-force and pin-force paths. The four load timings are tried with two different shadow values, so a command that loads early or late is visible.

// File: rtl/pwm_ovr_pkg.sv
package pwm_ovr_pkg;

  typedef enum logic [1:0] {
    REC_NOW    = 2'd0,
    REC_RELOAD = 2'd1,
    REC_EVENT  = 2'd2,
    REC_CLEAR  = 2'd3
  } recTrig_e;

  typedef enum logic [1:0] {
    FRC_LOW  = 2'd0,
    FRC_HIGH = 2'd1,
    FRC_HIZ  = 2'd2,
    FRC_NONE = 2'd3
  } frcCmd_e;

  typedef enum logic [1:0] {
    LD_NOW    = 2'd0,
    LD_RELOAD = 2'd1,
    LD_SYNC   = 2'd2,
    LD_NEVER  = 2'd3
  } frcLoad_e;

  typedef enum logic [1:0] {
    FM_DRV0 = 2'd0,
    FM_DRV1 = 2'd1,
    FM_HIZ  = 2'd2,
    FM_HIZ2 = 2'd3
  } fltMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic faultNow;   // any enabled fault source active
    logic reloadStb;  // counter reload pulse
    logic evtStb;     // selected recEvt transition
    logic clrStb;     // software clear pulse
    logic cmdLoad;    // copy shadow force command this edge
    logic forcePin;   // force pin at its active level
  } ovrStrobe_t;

endpackage

// File: rtl/pwm_ovr_ctrl.sv
module pwm_ovr_ctrl
  import pwm_ovr_pkg::*;
#(
  parameter int NINT = 4,
  parameter int NEXT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NINT-1:0]  intFault,
  input  logic [NINT-1:0]  intFaultEn,
  input  logic [NEXT-1:0]  extFault,
  input  logic [NEXT-1:0]  extFaultEn,
  input  logic [NEXT-1:0]  extActLow,
  input  logic             dbgFault,
  input  logic             dbgFaultEn,
  input  logic             recEvt,
  input  logic             recEdgeRise,
  input  logic             cntReload,
  input  logic             faultClr,
  input  logic             forceIn,
  input  logic             forcePolLow,
  input  logic [1:0]       forceTiming,
  input  logic             syncIn,
  output ovrStrobe_t       stb
);

  logic            evtPrev;
  logic [NEXT-1:0] extAct;
  logic            evtRise;
  logic            evtFall;
  frcLoad_e        loadSel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evtPrev <= 1'b0;
    else        evtPrev <= recEvt;
  end

  assign extAct  = extFault ^ extActLow;
  assign evtRise = recEvt & ~evtPrev;
  assign evtFall = ~recEvt & evtPrev;
  assign loadSel = frcLoad_e'(forceTiming);

  always_comb begin
    stb.faultNow  = (|(intFault & intFaultEn)) | (|(extAct & extFaultEn))
                  | (dbgFault & dbgFaultEn);
    stb.reloadStb = cntReload;
    stb.evtStb    = recEdgeRise ? evtRise : evtFall;
    stb.clrStb    = faultClr;
    stb.forcePin  = forceIn ^ forcePolLow;
    unique case (loadSel)
      LD_NOW:    stb.cmdLoad = 1'b1;
      LD_RELOAD: stb.cmdLoad = cntReload;
      LD_SYNC:   stb.cmdLoad = syncIn;
      default:   stb.cmdLoad = 1'b0;
    endcase
  end

endmodule

// File: rtl/pwm_ovr_dp.sv
module pwm_ovr_dp
  import pwm_ovr_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ovrStrobe_t        stb,
  input  logic [NCH-1:0]    pwmRaw,
  input  logic [NCH-1:0]    outInvert,
  input  logic [NCH-1:0]    outEnable,
  input  logic [2*NCH-1:0]  faultMode,
  input  logic [2*NCH-1:0]  recTrig,
  input  logic              swForce,
  input  logic [NCH-1:0]    forceSrcSw,
  input  logic [2*NCH-1:0]  forceCmdShadow,
  output logic [NCH-1:0]    pwmOut,
  output logic [NCH-1:0]    pwmOe,
  output logic [NCH-1:0]    holdVec,
  output logic [2*NCH-1:0]  forceWork
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          forceWork <= '1;
    else if (stb.cmdLoad) forceWork <= forceCmdShadow;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    recTrig_e trig;
    frcCmd_e  cmd;
    fltMode_e mode;
    logic     relGo;
    logic     chFault;
    logic     frcAct;
    logic     o;
    logic     e;

    assign trig = recTrig_e'(recTrig[2*i +: 2]);
    assign cmd  = frcCmd_e'(forceWork[2*i +: 2]);
    assign mode = fltMode_e'(faultMode[2*i +: 2]);

    always_comb begin
      unique case (trig)
        REC_NOW:    relGo = 1'b1;
        REC_RELOAD: relGo = stb.reloadStb;
        REC_EVENT:  relGo = stb.evtStb;
        default:    relGo = stb.clrStb;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            holdVec[i] <= 1'b0;
      else if (stb.faultNow) holdVec[i] <= 1'b1;
      else if (relGo)        holdVec[i] <= 1'b0;
    end

    assign chFault = stb.faultNow | holdVec[i];
    assign frcAct  = forceSrcSw[i] ? swForce : stb.forcePin;

    always_comb begin
      o = pwmRaw[i] ^ outInvert[i];
      e = 1'b1;
      if (frcAct) begin
        unique case (cmd)
          FRC_LOW:  o = 1'b0;
          FRC_HIGH: o = 1'b1;
          FRC_HIZ:  begin o = 1'b0; e = 1'b0; end
          default:  ;
        endcase
      end
      if (chFault) begin
        unique case (mode)
          FM_DRV0: begin o = 1'b0; e = 1'b1; end
          FM_DRV1: begin o = 1'b1; e = 1'b1; end
          default: begin o = 1'b0; e = 1'b0; end
        endcase
      end
      if (!outEnable[i]) begin
        o = 1'b0;
        e = 1'b0;
      end
    end

    assign pwmOut[i] = o;
    assign pwmOe[i]  = e;
  end

endmodule

// File: rtl/pwm_override.sv
module pwm_override
  import pwm_ovr_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int NINT = 4,
  parameter int NEXT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    pwmRaw,
  input  logic [NCH-1:0]    outInvert,
  input  logic [NCH-1:0]    outEnable,
  input  logic [NINT-1:0]   intFault,
  input  logic [NINT-1:0]   intFaultEn,
  input  logic [NEXT-1:0]   extFault,
  input  logic [NEXT-1:0]   extFaultEn,
  input  logic [NEXT-1:0]   extActLow,
  input  logic              dbgFault,
  input  logic              dbgFaultEn,
  input  logic [2*NCH-1:0]  faultMode,
  input  logic [2*NCH-1:0]  recTrig,
  input  logic              recEvt,
  input  logic              recEdgeRise,
  input  logic              cntReload,
  input  logic              faultClr,
  input  logic              forceIn,
  input  logic              forcePolLow,
  input  logic              swForce,
  input  logic [NCH-1:0]    forceSrcSw,
  input  logic [2*NCH-1:0]  forceCmdShadow,
  input  logic [1:0]        forceTiming,
  input  logic              syncIn,
  output logic [NCH-1:0]    pwmOut,
  output logic [NCH-1:0]    pwmOe
);

  localparam int CMDW = 2 * NCH;

  ovrStrobe_t      stb;
  logic [NCH-1:0]  holdVec;
  logic [CMDW-1:0] forceWork;

  pwm_ovr_ctrl #(.NINT(NINT), .NEXT(NEXT)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .intFault(intFault), .intFaultEn(intFaultEn),
    .extFault(extFault), .extFaultEn(extFaultEn), .extActLow(extActLow),
    .dbgFault(dbgFault), .dbgFaultEn(dbgFaultEn),
    .recEvt(recEvt), .recEdgeRise(recEdgeRise),
    .cntReload(cntReload), .faultClr(faultClr),
    .forceIn(forceIn), .forcePolLow(forcePolLow),
    .forceTiming(forceTiming), .syncIn(syncIn),
    .stb(stb)
  );

  pwm_ovr_dp #(.NCH(NCH)) dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .pwmRaw(pwmRaw), .outInvert(outInvert), .outEnable(outEnable),
    .faultMode(faultMode), .recTrig(recTrig),
    .swForce(swForce), .forceSrcSw(forceSrcSw),
    .forceCmdShadow(forceCmdShadow),
    .pwmOut(pwmOut), .pwmOe(pwmOe),
    .holdVec(holdVec), .forceWork(forceWork)
  );

endmodule

// File: rtl/pwm_override_chk.sv
module pwm_override_chk #(
  parameter int NCH  = 8,
  parameter int NINT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    outEnable,
  input logic [NCH-1:0]    pwmOe,
  input logic [1:0]        forceTiming,
  input logic [2*NCH-1:0]  forceWork,
  input logic [NCH-1:0]    holdVec,
  input logic [2*NCH-1:0]  recTrig,
  input logic              faultClr,
  input logic              cntReload,
  input logic [NINT-1:0]   intFault,
  input logic [NINT-1:0]   intFaultEn,
  input logic              dbgFault,
  input logic              dbgFaultEn
);

  // R12
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwmOe & ~outEnable) == '0);

  // R9
  never_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    forceTiming == 2'd3 |=> $stable(forceWork));

  // R1
  int_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(intFault & intFaultEn)) |=> (&holdVec));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R3
    hold_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(holdVec[i]) |-> $past(((intFault & intFaultEn) == '0) && !(dbgFault && dbgFaultEn)));

    // R5
    reload_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(holdVec[i]) && $past(recTrig[2*i +: 2]) == 2'd1) |-> $past(cntReload));

    // R7
    clr_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(holdVec[i]) && $past(recTrig[2*i +: 2]) == 2'd3) |-> $past(faultClr));
  end

endmodule

bind pwm_override pwm_override_chk #(.NCH(NCH), .NINT(NINT)) chk_i (
  .clk(clk), .rst_n(rst_n), .outEnable(outEnable), .pwmOe(pwmOe),
  .forceTiming(forceTiming), .forceWork(forceWork), .holdVec(holdVec),
  .recTrig(recTrig), .faultClr(faultClr), .cntReload(cntReload),
  .intFault(intFault), .intFaultEn(intFaultEn),
  .dbgFault(dbgFault), .dbgFaultEn(dbgFaultEn)
);

// File: tb/pwm_override_tb.sv
module pwm_override_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pwmRaw = '0, outInvert = '0, outEnable = 8'hFF;
  logic [3:0]  intFault = '0, intFaultEn = '0;
  logic [1:0]  extFault = '0, extFaultEn = '0, extActLow = '0;
  logic        dbgFault = 1'b0, dbgFaultEn = 1'b0;
  logic [15:0] faultMode = 16'hE4E4, recTrig = 16'hE4E4;
  logic        recEvt = 1'b0, recEdgeRise = 1'b1, cntReload = 1'b0, faultClr = 1'b0;
  logic        forceIn = 1'b0, forcePolLow = 1'b0, swForce = 1'b0;
  logic [7:0]  forceSrcSw = 8'hF0;
  logic [15:0] forceCmdShadow = 16'hE4E4;
  logic [1:0]  forceTiming = 2'd3;
  logic        syncIn = 1'b0;
  logic [7:0]  pwmOut, pwmOe;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  pwm_override dut_i (
    .clk(clk), .rst_n(rst_n), .pwmRaw(pwmRaw), .outInvert(outInvert),
    .outEnable(outEnable), .intFault(intFault), .intFaultEn(intFaultEn),
    .extFault(extFault), .extFaultEn(extFaultEn), .extActLow(extActLow),
    .dbgFault(dbgFault), .dbgFaultEn(dbgFaultEn), .faultMode(faultMode),
    .recTrig(recTrig), .recEvt(recEvt), .recEdgeRise(recEdgeRise),
    .cntReload(cntReload), .faultClr(faultClr), .forceIn(forceIn),
    .forcePolLow(forcePolLow), .swForce(swForce), .forceSrcSw(forceSrcSw),
    .forceCmdShadow(forceCmdShadow), .forceTiming(forceTiming),
    .syncIn(syncIn), .pwmOut(pwmOut), .pwmOe(pwmOe)
  );

  // {raw, inv, 7'b0 forceIn, 7'b0 swForce, expOut, expOe}
  // force cmd E4E4: ch0/4=drive0, ch1/5=drive1, ch2/6=hi-Z, ch3/7=none; ch0-3 pin, ch4-7 sw
  localparam logic [47:0] VECS [0:5] = '{
    {8'hA5, 8'h00, 8'h00, 8'h00, 8'hA5, 8'hFF},
    {8'hA5, 8'h0F, 8'h00, 8'h00, 8'hAA, 8'hFF},
    {8'hFF, 8'h00, 8'h01, 8'h00, 8'hFA, 8'hFB},
    {8'h00, 8'h00, 8'h00, 8'h01, 8'h20, 8'hBF},
    {8'h0F, 8'hF0, 8'h01, 8'h01, 8'hAA, 8'hBB},
    {8'h3C, 8'hFF, 8'h00, 8'h00, 8'hC3, 8'hFF}
  };

  task automatic check(input string req, input logic [7:0] expO, input logic [7:0] expE);
    total++;
    if (pwmOut !== expO || pwmOe !== expE) begin
      bad++;
      $display("FAIL %s: out=%h oe=%h expected out=%h oe=%h", req, pwmOut, pwmOe, expO, expE);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
    #1;
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog: out=%h oe=%h expected completion", pwmOut, pwmOe);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13: reset state, force requested but working command is all "none"
    pwmRaw = 8'hA5; forceIn = 1'b1; swForce = 1'b1;
    #1 check("R13 reset", 8'hA5, 8'hFF);
    repeat (3) @(negedge clk);
    #1 check("R9 never load", 8'hA5, 8'hFF);
    // R9 reload timing
    forceTiming = 2'd1;
    @(negedge clk); #1 check("R9 reload wait", 8'hA5, 8'hFF);
    pulse(cntReload);
    check("R9 reload load", 8'hA2, 8'hBB);
    // R9 sync timing with a new shadow
    forceTiming = 2'd2; forceCmdShadow = 16'h0000;
    repeat (2) @(negedge clk);
    #1 check("R9 sync wait", 8'hA2, 8'hBB);
    pulse(syncIn);
    check("R9 sync load", 8'h00, 8'hFF);
    // R9 immediate timing
    forceTiming = 2'd0; forceCmdShadow = 16'hE4E4;
    @(negedge clk); @(negedge clk);
    #1 check("R9 immediate load", 8'hA2, 8'hBB);

    // R8 R11 table
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      pwmRaw = VECS[k][47:40]; outInvert = VECS[k][39:32];
      forceIn = VECS[k][24]; swForce = VECS[k][16];
      #1 check("R8 R11 table", VECS[k][15:8], VECS[k][7:0]);
    end
    // R8 pin polarity
    @(negedge clk);
    pwmRaw = 8'hFF; outInvert = '0; forceIn = 1'b0; swForce = 1'b0; forcePolLow = 1'b1;
    #1 check("R8 active-low pin", 8'hFA, 8'hFB);
    forcePolLow = 1'b0;
    // R12
    @(negedge clk); outEnable = 8'h0F;
    #1 check("R12 oe gate", 8'h0F, 8'h0F);
    outEnable = 8'hFF;

    // faults: raw 55, modes/triggers E4E4
    @(negedge clk); pwmRaw = 8'h55; intFault = 4'b0001;
    #1 check("R1 disabled source", 8'h55, 8'hFF);
    intFaultEn = 4'b0001;
    #1 check("R1 R2 internal fault", 8'h22, 8'h33);
    @(negedge clk);
    cntReload = 1'b1; faultClr = 1'b1; recEvt = 1'b1;
    @(negedge clk);
    cntReload = 1'b0; faultClr = 1'b0; recEvt = 1'b0;
    #1 check("R3 release blocked", 8'h22, 8'h33);
    forceIn = 1'b1;
    #1 check("R10 fault over force", 8'h22, 8'h33);
    forceIn = 1'b0;
    @(negedge clk); intFault = '0;
    #1 check("R3 hold after drop", 8'h22, 8'h33);
    @(negedge clk); #1 check("R4 immediate", 8'h33, 8'h33);
    pulse(cntReload);
    check("R5 reload", 8'h11, 8'h33);
    @(negedge clk); recEvt = 1'b1;
    @(negedge clk); #1 check("R6 rising", 8'h55, 8'h77);
    recEvt = 1'b0;
    @(negedge clk); #1 check("R6 falling ignored", 8'h55, 8'h77);
    pulse(faultClr);
    check("R7 clear", 8'h55, 8'hFF);

    // external, active low, and falling-edge recovery
    @(negedge clk);
    extActLow = 2'b01; extFault = 2'b10; extFaultEn = 2'b01;
    #1 check("R1 external active low", 8'h22, 8'h33);
    @(negedge clk); extFault = 2'b11; recEdgeRise = 1'b0;
    @(negedge clk); #1 check("R4 external drop", 8'h33, 8'h33);
    pulse(cntReload);
    check("R5 reload 2", 8'h11, 8'h33);
    @(negedge clk); recEvt = 1'b1;
    @(negedge clk); #1 check("R6 rising ignored", 8'h11, 8'h33);
    recEvt = 1'b0;
    @(negedge clk); #1 check("R6 falling", 8'h55, 8'h77);
    pulse(faultClr);
    check("R7 clear 2", 8'h55, 8'hFF);

    // debug source
    @(negedge clk); dbgFault = 1'b1; dbgFaultEn = 1'b1;
    #1 check("R1 R2 debug fault", 8'h22, 8'h33);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule